// File: doc/BRIEF.md
# Capture/Compare Timer with Handshake-Cleared Event Flags

This block is a 16-bit free-running timer that a processor reaches over an 8-bit register bus. It timestamps edges on two capture pins, raises a match event when the count equals either of two compare values, and notes each wrap of the count from all ones to zero. Five event flags collect these events in one read-only status byte. Three interrupt request lines are each gated by an enable bit in the control byte.

A flag is never cleared by a single access. Software first reads the status byte while the flag is set. It then touches the low byte of that flag's own data register. If a new event for that flag arrives between the two steps, the first step is cancelled and the flag stays set. A second copy of the counter can be read at any time and takes no part in any clearing sequence. Reading the high byte of the counter, of the alternate counter or of a capture register freezes the matching low byte, so the two halves read as one value.

Top module: `tmr_status_top`

## Requirements
- R1: After reset the status byte (offset 0x1) reads 0x00, the control byte (offset 0x0) reads 0x00 and all three interrupt lines are low.
- R2: The counter advances by one on every clock. A read of a high byte (counter 0x6, alternate 0x8, capture 0x2/0xA) holds that register's low byte, and the next read of the low byte (0x7, 0x9, 0x3/0xB) returns the held value.
- R3: When the counter wraps from 0xFFFF to 0x0000, status bit 5 (overflow) is set.
- R4: An edge on capture pin c of the polarity chosen by control bit c (1 = rising, 0 = falling) stores the counter in capture register c and sets status bit 7 (c=0) or bit 4 (c=1). An edge of the other polarity changes nothing.
- R5: When the counter equals compare register 0 (0x4/0x5) or 1 (0xC/0xD), status bit 6 or bit 3 respectively is set.
- R6: A flag clears when a read of the status byte that sees it set is followed by an access to its own register: a read of 0x3 (bit 7), a read or write of 0x5 (bit 6), a read of 0x7 (bit 5), a read of 0xB (bit 4), a read or write of 0xD (bit 3).
- R7: An access to a flag's clearing register with no earlier status read that saw the flag set leaves the flag set.
- R8: If a flag's event recurs after the status read and before the clearing access, the access leaves the flag set.
- R9: Reading the alternate counter (0x8/0x9) returns the count and never clears the overflow flag, whether or not the status byte was read before.
- R10: One cycle after a change, irq_cap equals control bit 7 AND (bit 7 OR bit 4 of status), irq_cmp equals control bit 6 AND (bit 6 OR bit 3), and irq_ovf equals control bit 5 AND bit 5.
- R11: Writing the low byte of a compare register completes that flag's clearing sequence just as a read does.
- R12: Writes to the status byte have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| cap_pin | input | 2 | Capture inputs, synchronised inside |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
A stuck or stale arm bit shows up on the very next clearing access. The flag then either stays set when the handshake was complete, or drops when a recurring event or an alternate-counter read should have kept it. A status read one access later exposes either error. A broken byte latch shows as a counter pair that is off by far more than the cycles between reads, on the read right after the high byte. A wrong edge polarity or compare term leaves a status bit wrong within a few cycles of the stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int OFF_W = 4;
  // register offsets
  localparam logic [OFF_W-1:0] A_CTRL   = 4'h0;
  localparam logic [OFF_W-1:0] A_STAT   = 4'h1;
  localparam logic [OFF_W-1:0] A_CAP0_H = 4'h2;
  localparam logic [OFF_W-1:0] A_CAP0_L = 4'h3;
  localparam logic [OFF_W-1:0] A_CMP0_H = 4'h4;
  localparam logic [OFF_W-1:0] A_CMP0_L = 4'h5;
  localparam logic [OFF_W-1:0] A_CNT_H  = 4'h6;
  localparam logic [OFF_W-1:0] A_CNT_L  = 4'h7;
  localparam logic [OFF_W-1:0] A_ALT_H  = 4'h8;
  localparam logic [OFF_W-1:0] A_ALT_L  = 4'h9;
  localparam logic [OFF_W-1:0] A_CAP1_H = 4'hA;
  localparam logic [OFF_W-1:0] A_CAP1_L = 4'hB;
  localparam logic [OFF_W-1:0] A_CMP1_H = 4'hC;
  localparam logic [OFF_W-1:0] A_CMP1_L = 4'hD;
  // control bits
  localparam int CTL_RISE0  = 0;
  localparam int CTL_RISE1  = 1;
  localparam int CTL_OVF_IE = 5;
  localparam int CTL_CMP_IE = 6;
  localparam int CTL_CAP_IE = 7;
  // flag vector indices; status byte = {flags, zeros}
  localparam int NFLAG  = 5;
  localparam int F_CAP0 = 4;
  localparam int F_CMP0 = 3;
  localparam int F_OVF  = 2;
  localparam int F_CAP1 = 1;
  localparam int F_CMP1 = 0;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign wrap = &cnt;

  // R3
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)) else $error("counter did not wrap to zero");
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W  = 16,
  parameter int CH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CH-1:0]        pin,
  input  logic [CH-1:0]        rise_sel,
  input  logic [W-1:0]         cnt,
  output logic [CH-1:0][W-1:0] cap_val,
  output logic [CH-1:0]        cap_evt
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      end else begin
        s1 <= pin[c]; s2 <= s1; s3 <= s2;
      end
    end
    assign cap_evt[c] = rise_sel[c] ? (s2 & ~s3) : (~s2 & s3);
    always_ff @(posedge clk) begin
      if (rst)             cap_val[c] <= '0;
      else if (cap_evt[c]) cap_val[c] <= cnt;
    end
  end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W  = 16,
  parameter int CH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CH-1:0]        wr_hi,
  input  logic [CH-1:0]        wr_lo,
  input  logic [W/2-1:0]       wdata,
  input  logic [W-1:0]         cnt,
  output logic [CH-1:0][W-1:0] cmp_val,
  output logic [CH-1:0]        match_evt
);
  localparam int HW = W / 2;
  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) cmp_val[c] <= '1;
      else begin
        if (wr_hi[c]) cmp_val[c][W-1:HW] <= wdata;
        if (wr_lo[c]) cmp_val[c][HW-1:0] <= wdata;
      end
    end
    assign match_evt[c] = (cnt == cmp_val[c]);
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_acc,
  input  logic         stat_rd,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_f
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else if (set_evt[i]) begin
        flag_q[i] <= 1'b1;
        arm_q[i]  <= 1'b0;
      end else if (clr_acc[i] && arm_q[i]) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else if (stat_rd && flag_q[i]) begin
        arm_q[i]  <= 1'b1;
      end
    end

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[i]) |-> $past(clr_acc[i] && arm_q[i]))
      else $error("flag cleared without handshake");
    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[i]) |-> $past(set_evt[i]))
      else $error("flag rose without event");
    // R8
    event_kept_chk: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flag_q[i])
      else $error("event lost");
  end
endmodule

// File: rtl/tmr_status_top.sv
module tmr_status_top
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [1:0]        cap_pin,
  output logic              irq_cap,
  output logic              irq_cmp,
  output logic              irq_ovf
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int NCH   = 2;

  logic rd, wrs;
  assign rd  = sel & ~wr;
  assign wrs = sel & wr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFF_W-1:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic [DATA_W-1:0]           ctrl_q;
  logic [CNT_W-1:0]            cnt;
  logic                        wrap;
  logic [NCH-1:0][CNT_W-1:0]   cap_val, cmp_val;
  logic [NCH-1:0]              cap_evt, cmp_evt;
  logic [NFLAG-1:0]            flags, set_evt, clr_acc;
  logic [DATA_W-1:0]           status;

  tmr_counter #(.W(CNT_W)) u_cnt (.clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap));

  tmr_capture #(.W(CNT_W), .CH(NCH)) u_cap (
    .clk(clk), .rst(rst), .pin(cap_pin),
    .rise_sel({ctrl_q[CTL_RISE1], ctrl_q[CTL_RISE0]}),
    .cnt(cnt), .cap_val(cap_val), .cap_evt(cap_evt));

  tmr_compare #(.W(CNT_W), .CH(NCH)) u_cmp (
    .clk(clk), .rst(rst),
    .wr_hi({wrs & hit(addr, A_CMP1_H), wrs & hit(addr, A_CMP0_H)}),
    .wr_lo({wrs & hit(addr, A_CMP1_L), wrs & hit(addr, A_CMP0_L)}),
    .wdata(wdata), .cnt(cnt), .cmp_val(cmp_val), .match_evt(cmp_evt));

  always_comb begin
    set_evt         = '0;
    set_evt[F_CAP0] = cap_evt[0];
    set_evt[F_CMP0] = cmp_evt[0];
    set_evt[F_OVF]  = wrap;
    set_evt[F_CAP1] = cap_evt[1];
    set_evt[F_CMP1] = cmp_evt[1];
    clr_acc         = '0;
    clr_acc[F_CAP0] = rd  & hit(addr, A_CAP0_L);
    clr_acc[F_CMP0] = sel & hit(addr, A_CMP0_L);
    clr_acc[F_OVF]  = rd  & hit(addr, A_CNT_L);
    clr_acc[F_CAP1] = rd  & hit(addr, A_CAP1_L);
    clr_acc[F_CMP1] = sel & hit(addr, A_CMP1_L);
  end

  tmr_flags #(.N(NFLAG)) u_flg (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_acc(clr_acc),
    .stat_rd(rd & hit(addr, A_STAT)), .flag_q(flags));

  assign status = {flags, {(DATA_W-NFLAG){1'b0}}};

  // byte latches: counter, alternate counter, captures
  logic [DATA_W-1:0] cnt_lat, alt_lat;
  logic              cnt_lv, alt_lv;
  logic [NCH-1:0][DATA_W-1:0] cap_lat;
  logic [NCH-1:0]             cap_lv;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lat <= '0; cnt_lv <= 1'b0;
      alt_lat <= '0; alt_lv <= 1'b0;
    end else begin
      if (rd & hit(addr, A_CNT_H))      begin cnt_lat <= cnt[DATA_W-1:0]; cnt_lv <= 1'b1; end
      else if (rd & hit(addr, A_CNT_L)) cnt_lv <= 1'b0;
      if (rd & hit(addr, A_ALT_H))      begin alt_lat <= cnt[DATA_W-1:0]; alt_lv <= 1'b1; end
      else if (rd & hit(addr, A_ALT_L)) alt_lv <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_caplat
    localparam logic [OFF_W-1:0] OH = (c == 0) ? A_CAP0_H : A_CAP1_H;
    localparam logic [OFF_W-1:0] OL = (c == 0) ? A_CAP0_L : A_CAP1_L;
    always_ff @(posedge clk) begin
      if (rst) begin
        cap_lat[c] <= '0; cap_lv[c] <= 1'b0;
      end else if (rd & hit(addr, OH)) begin
        cap_lat[c] <= cap_val[c][DATA_W-1:0]; cap_lv[c] <= 1'b1;
      end else if (rd & hit(addr, OL)) begin
        cap_lv[c] <= 1'b0;
      end
    end
  end

  // control register; status is read-only
  always_ff @(posedge clk) begin
    if (rst)                      ctrl_q <= '0;
    else if (wrs & hit(addr, A_CTRL)) ctrl_q <= wdata;
  end

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    case (addr)
      ADDR_W'(A_CTRL):   rmux = ctrl_q;
      ADDR_W'(A_STAT):   rmux = status;
      ADDR_W'(A_CAP0_H): rmux = cap_val[0][CNT_W-1:DATA_W];
      ADDR_W'(A_CAP0_L): rmux = cap_lv[0] ? cap_lat[0] : cap_val[0][DATA_W-1:0];
      ADDR_W'(A_CMP0_H): rmux = cmp_val[0][CNT_W-1:DATA_W];
      ADDR_W'(A_CMP0_L): rmux = cmp_val[0][DATA_W-1:0];
      ADDR_W'(A_CNT_H):  rmux = cnt[CNT_W-1:DATA_W];
      ADDR_W'(A_CNT_L):  rmux = cnt_lv ? cnt_lat : cnt[DATA_W-1:0];
      ADDR_W'(A_ALT_H):  rmux = cnt[CNT_W-1:DATA_W];
      ADDR_W'(A_ALT_L):  rmux = alt_lv ? alt_lat : cnt[DATA_W-1:0];
      ADDR_W'(A_CAP1_H): rmux = cap_val[1][CNT_W-1:DATA_W];
      ADDR_W'(A_CAP1_L): rmux = cap_lv[1] ? cap_lat[1] : cap_val[1][DATA_W-1:0];
      ADDR_W'(A_CMP1_H): rmux = cmp_val[1][CNT_W-1:DATA_W];
      ADDR_W'(A_CMP1_L): rmux = cmp_val[1][DATA_W-1:0];
      default:           rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_cap <= 1'b0;
      irq_cmp <= 1'b0;
      irq_ovf <= 1'b0;
    end else begin
      if (rd) rdata <= rmux;
      irq_cap <= ctrl_q[CTL_CAP_IE] & (flags[F_CAP0] | flags[F_CAP1]);
      irq_cmp <= ctrl_q[CTL_CMP_IE] & (flags[F_CMP0] | flags[F_CMP1]);
      irq_ovf <= ctrl_q[CTL_OVF_IE] & flags[F_OVF];
    end
  end

  // R10
  irq_ovf_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> $past(ctrl_q[CTL_OVF_IE])) else $error("overflow irq without enable");
  // R12
  stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wrs & hit(addr, A_STAT)) |=> ($past(set_evt) != '0 || flags == $past(flags)))
    else $error("status write changed flags");
endmodule

// File: tb/tmr_status_top_bench.sv
module tmr_status_top_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cap_pin = 2'b10;
  logic irq_cap, irq_cmp, irq_ovf;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr_status_top u_tmr_status_top (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_pin(cap_pin), .irq_cap(irq_cap), .irq_cmp(irq_cmp),
    .irq_ovf(irq_ovf));

  typedef struct {
    logic [7:0] e;
    logic [7:0] m;
    string      r;
  } exp_t;
  exp_t exp_q[$];

  // monitor: pops expected item for each read strobe
  always @(posedge clk) begin
    if (sel === 1'b1 && wr === 1'b0) begin
      #1;
      if (exp_q.size() != 0) begin
        exp_t it;
        it = exp_q.pop_front();
        if (it.m != 8'h00) begin
          checks++;
          if ((rdata & it.m) !== (it.e & it.m)) begin
            errors++;
            $display("FAIL %s: read %h expected %h (mask %h)", it.r, rdata & it.m, it.e & it.m, it.m);
          end
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input logic [7:0] m,
                    input string r, output logic [7:0] got);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    exp_q.push_back('{e, m, r});
    @(posedge clk); #1 got = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wrb(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic chk(input string r, input int act, input int ex);
    checks++;
    if (act != ex) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, ex);
    end
  endtask

  task automatic rd16(input logic [3:0] ah, output int v);
    logic [7:0] h, l;
    rd(ah, 8'h00, 8'h00, "pair", h);
    rd(ah + 4'h1, 8'h00, 8'h00, "pair", l);
    v = {h, l};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int a, b, c, v;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 irqs", {irq_cap, irq_cmp, irq_ovf}, 0);
    rd(4'h1, 8'h00, 8'hF8, "R1 status", d);
    rd(4'h0, 8'h00, 8'hFF, "R1 ctrl", d);
    // R12 status write ignored
    wrb(4'h1, 8'hFF);
    rd(4'h1, 8'h00, 8'hF8, "R12 status after write", d);

    // R2 / R9 pair reads: alt hi at E, cnt hi at E+4
    rd16(4'h8, a);
    rd16(4'h6, b);
    chk("R2 R9 pair delta", b - a, 4);

    // R5 compares
    c = b + 100;
    wrb(4'h4, c[15:8]); wrb(4'h5, c[7:0]);
    c = b + 120;
    wrb(4'hC, c[15:8]); wrb(4'hD, c[7:0]);
    repeat (150) @(posedge clk);
    rd(4'h1, 8'h48, 8'h48, "R5 compare flags", d);
    // R6 compare 0 cleared by low read
    rd(4'h5, 8'h00, 8'h00, "clr", d);
    rd(4'h1, 8'h08, 8'h48, "R6 cmp0 cleared", d);
    // R11 compare 1 cleared by low write
    wrb(4'hD, 8'h00);
    rd(4'h1, 8'h00, 8'h08, "R11 cmp1 cleared", d);

    // R4 ignored polarity: ch0 falling selected, rising edge
    cap_pin[0] = 1'b1;
    repeat (8) @(posedge clk);
    rd(4'h1, 8'h00, 8'h80, "R4 wrong edge rising", d);
    wrb(4'h0, 8'h01);
    cap_pin[0] = 1'b0;
    repeat (8) @(posedge clk);
    rd(4'h1, 8'h00, 8'h80, "R4 wrong edge falling", d);
    // R4 capture on rising
    rd16(4'h8, a);
    cap_pin[0] = 1'b1;
    repeat (10) @(posedge clk);
    chk("R10 irq_cap disabled", irq_cap, 0);
    rd16(4'h2, v); // R7: low read without status read
    chk("R4 capture window", (v - a >= 3 && v - a <= 16) ? 1 : 0, 1);
    rd(4'h1, 8'h80, 8'h80, "R7 flag kept", d);
    // R8 new event between steps
    cap_pin[0] = 1'b0;
    repeat (6) @(posedge clk);
    cap_pin[0] = 1'b1;
    repeat (8) @(posedge clk);
    rd(4'h3, 8'h00, 8'h00, "clr", d);
    rd(4'h1, 8'h80, 8'h80, "R8 flag kept", d);
    // R10 irq enable
    wrb(4'h0, 8'h81);
    @(negedge clk);
    chk("R10 irq_cap on", irq_cap, 1);
    // R6 cap0 clear
    rd(4'h3, 8'h00, 8'h00, "clr", d);
    rd(4'h1, 8'h00, 8'h80, "R6 cap0 cleared", d);
    chk("R10 irq_cap off", irq_cap, 0);
    // channel 1 falling edge
    cap_pin[1] = 1'b0;
    repeat (10) @(posedge clk);
    rd(4'h1, 8'h10, 8'h10, "R4 cap1 flag", d);
    rd(4'hB, 8'h00, 8'h00, "clr", d);
    rd(4'h1, 8'h00, 8'h10, "R6 cap1 cleared", d);

    // R3 overflow
    wrb(4'h0, 8'h20);
    rd16(4'h8, a);
    repeat (65536 - a + 20) @(posedge clk);
    rd(4'h1, 8'h20, 8'h20, "R3 overflow flag", d);
    @(negedge clk);
    chk("R10 irq_ovf on", irq_ovf, 1);
    rd16(4'h8, a);
    rd(4'h1, 8'h20, 8'h20, "R9 alt keeps ovf", d);
    rd16(4'h8, a);
    rd(4'h1, 8'h20, 8'h20, "R9 alt keeps ovf armed", d);
    rd(4'h7, 8'h00, 8'h00, "clr", d);
    rd(4'h1, 8'h00, 8'h20, "R6 ovf cleared", d);
    @(negedge clk);
    chk("R10 irq_ovf off", irq_ovf, 0);

    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule